// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits on the cartridge side of an 8-bit handheld's bus and turns CPU writes into the ROM address range into control-register updates. It keeps four small registers: an external-RAM enable, a five-bit low bank field, a two-bit upper field and a mode bit. From these, together with static configuration pins, it drives three bank numbers. One is the ROM bank seen through the fixed low window. One is the ROM bank seen through the switchable high window. The third is the external RAM bank, which comes with its access-enable flag.

The write side is a plain strobe with address and data. It has no ready signal and no back-pressure: every cycle with the strobe high is one accepted write, and the block takes one write per clock. The ROM size and the RAM bank count are given as power-of-two logarithms. A multicart pin narrows the stride between the upper field and the low field from five bits to four. These configuration pins are static and are only changed while reset is held. All bank outputs are registered.

Top module: `cart_bank_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, hi_bank is 1, lo_bank is 0, ram_bank is 0 and ram_en is 0.
- R2: A write to region 0 with data 0x0A sets ram_en. A write to region 0 with data 0x00 clears it. Any other data value leaves ram_en unchanged.
- R3: A write to region 1 takes data[4:0] as the low field. A value of 0 is replaced by 1, and the result is then masked to the stride width: 5 bits normally, 4 bits with multicart set.
- R4: hi_bank is (upper << stride) | low, where stride is 5, or 4 when multicart is 1. The upper field is data[1:0] of a write to region 2.
- R5: A write to region 3 keeps only data[0] as the mode. In mode 1, lo_bank is (upper << stride) and ram_bank is upper. In mode 0, both are 0.
- R6: Every ROM bank result is masked with (2^rom_banks_log2 − 1). If the masked hi_bank result is 0, hi_bank is driven as 1.
- R7: ram_bank is masked with (2^ram_banks_log2 − 1).
- R8: All outputs change on the clock edge that samples the write strobe, and they hold their value on cycles without a write.
- R9: The region is wr_addr[15:13]. Writes with wr_addr[15] set (regions 4 to 7) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one write per cycle |
| wr_addr | input | 16 | Write address; bits [15:13] select the region |
| wr_data | input | 8 | Write data |
| rom_banks_log2 | input | 3 | log2 of the ROM bank count (1 to 7), static |
| ram_banks_log2 | input | 2 | log2 of the RAM bank count (0 to 2), static |
| multicart | input | 1 | 1 selects the 4-bit stride, static |
| lo_bank | output | 7 | ROM bank for the fixed low window |
| hi_bank | output | 7 | ROM bank for the switchable high window |
| ram_bank | output | 2 | External RAM bank |
| ram_en | output | 1 | External RAM access enable |

## Verification
Every register feeds an output directly through the mapping logic. A wrong low, upper or mode value therefore shows as a wrong bank number on the clock edge that accepts the write, or at the latest after the next write that brings that field into view. The upper field stays hidden in lo_bank and ram_bank while mode is 0, so the bench switches to mode 1 to expose it. A stuck enable shows after the first 0x00 or 0x0A write to region 0. Masking errors appear only for small ROM sizes or with the multicart stride, so the bench rebuilds the configuration under reset to cover them.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam logic [2:0] REGION_RAM_EN = 3'd0;
  localparam logic [2:0] REGION_LOW    = 3'd1;
  localparam logic [2:0] REGION_UPPER  = 3'd2;
  localparam logic [2:0] REGION_MODE   = 3'd3;
  localparam logic [7:0] RAM_UNLOCK    = 8'h0A;
  localparam logic [7:0] RAM_LOCK      = 8'h00;
endpackage

// File: rtl/cbc_ctrl_regs.sv
module cbc_ctrl_regs
  import cart_bank_pkg::*;
#(
  parameter int LOW_W     = 5,
  parameter int UP_W      = 2,
  parameter int MC_STRIDE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             multicart,
  output logic             nxt_ram_en,
  output logic [LOW_W-1:0] nxt_low,
  output logic [UP_W-1:0]  nxt_up,
  output logic             nxt_mode
);
  localparam logic [LOW_W-1:0] MASK_STD = {LOW_W{1'b1}};
  localparam logic [LOW_W-1:0] MASK_MC  = LOW_W'((1 << MC_STRIDE) - 1);
  localparam logic [LOW_W-1:0] ONE_LOW  = LOW_W'(1);

  logic             ram_en_q, mode_q;
  logic [LOW_W-1:0] low_q, low_fix;
  logic [UP_W-1:0]  up_q;
  logic [2:0]       region;
  logic             unused_bits;

  assign region      = wr_addr[15:13];
  assign unused_bits = ^{wr_addr[12:0], wr_data[7:LOW_W]};

  always_comb begin
    low_fix = wr_data[LOW_W-1:0];
    if (low_fix == '0) low_fix = ONE_LOW;
    low_fix = low_fix & (multicart ? MASK_MC : MASK_STD);
  end

  always_comb begin
    nxt_ram_en = ram_en_q;
    nxt_low    = low_q;
    nxt_up     = up_q;
    nxt_mode   = mode_q;
    if (wr_en) begin
      case (region)
        REGION_RAM_EN: begin
          if (wr_data == RAM_UNLOCK)    nxt_ram_en = 1'b1;
          else if (wr_data == RAM_LOCK) nxt_ram_en = 1'b0;
        end
        REGION_LOW:   nxt_low  = low_fix;
        REGION_UPPER: nxt_up   = wr_data[UP_W-1:0];
        REGION_MODE:  nxt_mode = wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_en_q <= 1'b0;
      low_q    <= ONE_LOW;
      up_q     <= '0;
      mode_q   <= 1'b0;
    end else begin
      ram_en_q <= nxt_ram_en;
      low_q    <= nxt_low;
      up_q     <= nxt_up;
      mode_q   <= nxt_mode;
    end
  end
endmodule

// File: rtl/cbc_bank_map.sv
module cbc_bank_map #(
  parameter int LOW_W     = 5,
  parameter int UP_W      = 2,
  parameter int ROM_W     = 7,
  parameter int MC_STRIDE = 4,
  parameter int ROM_LW    = 3,
  parameter int RAM_LW    = 2
) (
  input  logic              [LOW_W-1:0]  low,
  input  logic              [UP_W-1:0]   up,
  input  logic                           mode,
  input  logic                           multicart,
  input  logic              [ROM_LW-1:0] rom_banks_log2,
  input  logic              [RAM_LW-1:0] ram_banks_log2,
  output logic              [ROM_W-1:0]  lo_bank,
  output logic              [ROM_W-1:0]  hi_bank,
  output logic              [UP_W-1:0]   ram_bank
);
  localparam logic [ROM_W:0] ONE_ROM = (ROM_W+1)'(1);
  localparam logic [UP_W:0]  ONE_RAM = (UP_W+1)'(1);

  logic [ROM_W:0]   rom_mask_full;
  logic [UP_W:0]    ram_mask_full;
  logic [ROM_W-1:0] rom_mask, up_sh, hi_raw;
  logic             mask_unused;

  assign rom_mask_full = (ONE_ROM << rom_banks_log2) - ONE_ROM;
  assign ram_mask_full = (ONE_RAM << ram_banks_log2) - ONE_RAM;
  assign rom_mask      = rom_mask_full[ROM_W-1:0];
  assign mask_unused   = rom_mask_full[ROM_W] ^ ram_mask_full[UP_W];

  generate
    if (MC_STRIDE < LOW_W) begin : g_two_strides
      assign up_sh = multicart ? (ROM_W'(up) << MC_STRIDE) : (ROM_W'(up) << LOW_W);
    end else begin : g_one_stride
      logic unused_mc;
      assign unused_mc = multicart;
      assign up_sh     = ROM_W'(up) << LOW_W;
    end
  endgenerate

  assign hi_raw   = (up_sh | ROM_W'(low)) & rom_mask;
  assign hi_bank  = (hi_raw == '0) ? ROM_W'(1) : hi_raw;
  assign lo_bank  = mode ? (up_sh & rom_mask) : '0;
  assign ram_bank = mode ? (up & ram_mask_full[UP_W-1:0]) : '0;
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
  parameter int LOW_W     = 5,
  parameter int UP_W      = 2,
  parameter int MC_STRIDE = 4,
  parameter int ROM_W     = LOW_W + UP_W,
  parameter int ROM_LW    = $clog2(ROM_W + 1),
  parameter int RAM_LW    = $clog2(UP_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ROM_LW-1:0] rom_banks_log2,
  input  logic [RAM_LW-1:0] ram_banks_log2,
  input  logic              multicart,
  output logic [ROM_W-1:0]  lo_bank,
  output logic [ROM_W-1:0]  hi_bank,
  output logic [UP_W-1:0]   ram_bank,
  output logic              ram_en
);
  logic             n_ram_en, n_mode;
  logic [LOW_W-1:0] n_low;
  logic [UP_W-1:0]  n_up, n_ram_bank;
  logic [ROM_W-1:0] n_lo_bank, n_hi_bank;

  cbc_ctrl_regs #(.LOW_W(LOW_W), .UP_W(UP_W), .MC_STRIDE(MC_STRIDE)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .multicart(multicart), .nxt_ram_en(n_ram_en), .nxt_low(n_low), .nxt_up(n_up),
    .nxt_mode(n_mode)
  );

  cbc_bank_map #(.LOW_W(LOW_W), .UP_W(UP_W), .ROM_W(ROM_W), .MC_STRIDE(MC_STRIDE),
                 .ROM_LW(ROM_LW), .RAM_LW(RAM_LW)) map_i (
    .low(n_low), .up(n_up), .mode(n_mode), .multicart(multicart),
    .rom_banks_log2(rom_banks_log2), .ram_banks_log2(ram_banks_log2),
    .lo_bank(n_lo_bank), .hi_bank(n_hi_bank), .ram_bank(n_ram_bank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_bank  <= '0;
      hi_bank  <= ROM_W'(1);
      ram_bank <= '0;
      ram_en   <= 1'b0;
    end else begin
      lo_bank  <= n_lo_bank;
      hi_bank  <= n_hi_bank;
      ram_bank <= n_ram_bank;
      ram_en   <= n_ram_en;
    end
  end

  logic [ROM_W:0] chk_rom_lim;
  assign chk_rom_lim = (ROM_W+1)'(1) << rom_banks_log2;

  assert_ramen_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:13] == 3'd0 && wr_data == 8'h0A) |=> ram_en);
  assert_ramen_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:13] == 3'd0 && wr_data != 8'h0A && wr_data != 8'h00)
      |=> $stable(ram_en));
  assert_mode0_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:13] == 3'd3 && !wr_data[0]) |=> (lo_bank == '0 && ram_bank == '0));
  assert_hi_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_bank != '0) && ({1'b0, hi_bank} < chk_rom_lim));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({lo_bank, hi_bank, ram_bank, ram_en}));
  assert_high_region_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15]) |=> $stable({lo_bank, hi_bank, ram_bank, ram_en}));
endmodule

// File: tb/cart_bank_ctrl_tb_top.sv
module cart_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rom_lg = 3'd7;
  logic [1:0]  ram_lg = 2'd2;
  logic        mc = 1'b0;
  logic [6:0]  lo_bank, hi_bank;
  logic [1:0]  ram_bank;
  logic        ram_en;

  always #5 clk = ~clk;

  cart_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rom_banks_log2(rom_lg), .ram_banks_log2(ram_lg), .multicart(mc),
    .lo_bank(lo_bank), .hi_bank(hi_bank), .ram_bank(ram_bank), .ram_en(ram_en)
  );

  typedef struct {
    logic [6:0] lo;
    logic [6:0] hi;
    logic [1:0] rb;
    logic       en;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  logic wrote = 1'b0;
  bit   done = 1'b0;

  logic       m_en, m_mode;
  logic [4:0] m_low;
  logic [1:0] m_up;

  function automatic exp_t model(string tag);
    exp_t e;
    int stride = mc ? 4 : 5;
    int rmask = (1 << rom_lg) - 1;
    int amask = (1 << ram_lg) - 1;
    int hi = ((int'(m_up) << stride) | int'(m_low)) & rmask;
    e.hi  = (hi == 0) ? 7'd1 : 7'(hi);
    e.lo  = m_mode ? 7'((int'(m_up) << stride) & rmask) : 7'd0;
    e.rb  = m_mode ? 2'(int'(m_up) & amask) : 2'd0;
    e.en  = m_en;
    e.tag = tag;
    return e;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_wr(logic [15:0] a, logic [7:0] d, string tag);
    int f;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (!a[15]) begin
      case (a[15:13])
        3'd0: if (d == 8'h0A) m_en = 1'b1; else if (d == 8'h00) m_en = 1'b0;
        3'd1: begin
          f = int'(d[4:0]);
          if (f == 0) f = 1;
          f = f & (mc ? 15 : 31);
          m_low = 5'(f);
        end
        3'd2: m_up = d[1:0];
        default: m_mode = d[0];
      endcase
    end
    q.push_back(model(tag));
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(logic [2:0] rl, logic [1:0] al, logic m);
    exp_t e;
    @(negedge clk);
    rst_n = 1'b0; rom_lg = rl; ram_lg = al; mc = m;
    m_en = 1'b0; m_mode = 1'b0; m_low = 5'd1; m_up = 2'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    e = model("R1");
    cmp("R1", "hi_bank", int'(hi_bank), int'(e.hi));
    cmp("R1", "lo_bank", int'(lo_bank), int'(e.lo));
    cmp("R1", "ram_bank", int'(ram_bank), int'(e.rb));
    cmp("R1", "ram_en", int'(ram_en), int'(e.en));
  endtask

  always @(posedge clk) wrote <= wr_en;

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (wrote && q.size() > 0) begin
        e = q.pop_front();
        cmp(e.tag, "hi_bank", int'(hi_bank), int'(e.hi));
        cmp(e.tag, "lo_bank", int'(lo_bank), int'(e.lo));
        cmp(e.tag, "ram_bank", int'(ram_bank), int'(e.rb));
        cmp(e.tag, "ram_en", int'(ram_en), int'(e.en));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    do_reset(3'd7, 2'd2, 1'b0);
    do_wr(16'h0000, 8'h0A, "R2");
    do_wr(16'h1FFF, 8'h05, "R2");
    do_wr(16'h0000, 8'h00, "R2");
    do_wr(16'h0000, 8'h0A, "R2");
    do_wr(16'h2000, 8'h00, "R3");
    do_wr(16'h2000, 8'h1F, "R3");
    do_wr(16'h3FFF, 8'hE3, "R3");
    do_wr(16'h4000, 8'h02, "R4");
    do_wr(16'h6000, 8'hFE, "R5");
    do_wr(16'h6000, 8'h01, "R5");
    do_wr(16'h4000, 8'h03, "R5");
    repeat (3) @(negedge clk);
    cmp("R8", "hi_bank idle", int'(hi_bank), 7'h63);
    do_wr(16'hA000, 8'h00, "R9");
    do_wr(16'hE000, 8'h0A, "R9");
    do_wr(16'h8000, 8'h1F, "R9");
    do_wr(16'h6000, 8'h00, "R5");
    do_reset(3'd5, 2'd1, 1'b0);
    do_wr(16'h4000, 8'h03, "R6");
    do_wr(16'h2000, 8'h07, "R6");
    do_wr(16'h6000, 8'h01, "R7");
    do_reset(3'd7, 2'd2, 1'b1);
    do_wr(16'h2000, 8'h1F, "R4");
    do_wr(16'h4000, 8'h02, "R4");
    do_wr(16'h2000, 8'h10, "R3");
    do_reset(3'd4, 2'd0, 1'b1);
    do_wr(16'h4000, 8'h01, "R6");
    do_wr(16'h2000, 8'h10, "R6");
    do_wr(16'h6000, 8'h01, "R7");
    repeat (3) @(negedge clk);
    cmp("R8", "queue drained", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule